// File: doc/BRIEF.md
# Memory Row/Bank Conflict Detector

This block watches a stream of memory command addresses, one for each cycle in which `cmd_valid` is high. It tells the command scheduler whether the new command lands in a different row, or a different bank, than the command accepted before it. Each flag compares the new address with the stored previous address over the bits that a mask selects. A flag is raised when any selected bit differs.

By default the row mask and the bank mask are built at elaboration from four parameters: the data width, the column width, the row width and the bank width. The address is divided into fields from the least-significant end upward: first the byte offset (log2 of data width / 8), then the column, then the row, then the bank. Any bits above the bank field take part in neither comparison. A runtime override lets software supply both masks instead. The block also outputs the decoded column, row and bank fields.

Address bits use big-endian numbering: big-endian bit b is port bit `ADDR_W-1-b`. With the default parameters (32-bit address, 32-bit data, 9 column bits, 13 row bits, 2 bank bits) the fields sit at these big-endian positions, which are these port bits:

| Field | Big-endian bits | Port bits |
|---|---|---|
| Column | 21–29 | [10:2] |
| Row | 8–20 | [23:11] |
| Bank | 6–7 | [25:24] |

Top module: `rowbank_conflict_detect`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `out_valid`, `row_conflict`, `bank_conflict` and all three field outputs are 0.
- R2: `out_valid` is high in exactly the cycle after a cycle with `cmd_valid` high, and is low otherwise.
- R3: In the cycle after an accepted command, `col_field` equals port bits [OFF_W+COL_W-1:OFF_W] of that command's address, where OFF_W = log2(DATA_W/8). With the defaults this is port bits [10:2], which are big-endian bits 21–29.
- R4: In the cycle after an accepted command, `row_field` equals the ROW_W bits directly above the column. With the defaults this is port bits [23:11], which are big-endian bits 8–20.
- R5: In the cycle after an accepted command, `bank_field` equals the BANK_W bits directly above the row. With the defaults this is port bits [25:24], which are big-endian bits 6–7.
- R6: The first command accepted after reset reports both `row_conflict` and `bank_conflict` as 1.
- R7: For each later command, `row_conflict` is 1 exactly when ((current XOR previous) AND row mask) is nonzero.
- R8: For each later command, `bank_conflict` is 1 exactly when ((current XOR previous) AND bank mask) is nonzero. It is evaluated independently of the row flag.
- R9: The stored previous address is loaded only on a cycle with `cmd_valid` high. Addresses presented while `cmd_valid` is low have no effect on later comparisons.
- R10: With `mask_ovr` low, the masks cover exactly the row field and exactly the bank field. A change confined to the offset, column or upper bits raises neither flag.
- R11: With `mask_ovr` high, `row_mask_in` and `bank_mask_in` are used as the masks for that command (port bit order).
- R12: In a cycle after `cmd_valid` was low, the flags and field outputs keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command address is presented and accepted this cycle |
| cmd_addr | input | ADDR_W | Command address; big-endian bit b is port bit ADDR_W-1-b |
| mask_ovr | input | 1 | Use the supplied masks instead of the derived ones |
| row_mask_in | input | ADDR_W | Supplied row-comparison mask |
| bank_mask_in | input | ADDR_W | Supplied bank-comparison mask |
| out_valid | output | 1 | Results below belong to the command of the previous cycle |
| row_conflict | output | 1 | Row differs from the previous command |
| bank_conflict | output | 1 | Bank differs from the previous command |
| col_field | output | COL_W | Decoded column |
| row_field | output | ROW_W | Decoded row |
| bank_field | output | BANK_W | Decoded bank |

## Verification
The assertions take for granted that `cmd_valid` and `rst` are never unknown after the first edge. They also assume that the parameters leave room for offset, column, row and bank inside ADDR_W. The stimulus drives every input to a known value from time zero and changes inputs only on the falling edge. It covers both states of `cmd_valid` and `mask_ovr`, and keeps the default field widths, which fit inside the 32-bit address with six spare upper bits. Those upper bits are randomised, so the check that the masks ignore them is exercised.

// File: rtl/rbc_pkg.sv
package rbc_pkg;
  // Contiguous run of w ones starting at bit lo (port bit order).
  function automatic logic [63:0] span_mask(input int lo, input int w);
    logic [63:0] m;
    m = '0;
    for (int i = 0; i < 64; i++)
      if (i >= lo && i < lo + w) m[i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/rbc_mask_gen.sv
module rbc_mask_gen #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 2,
  parameter int COL_W  = 9,
  parameter int ROW_W  = 13,
  parameter int BANK_W = 2
) (
  input  logic              mask_ovr,
  input  logic [ADDR_W-1:0] row_mask_in,
  input  logic [ADDR_W-1:0] bank_mask_in,
  output logic [ADDR_W-1:0] row_mask,
  output logic [ADDR_W-1:0] bank_mask
);
  import rbc_pkg::*;
  localparam int ROW_LO  = OFF_W + COL_W;
  localparam int BANK_LO = ROW_LO + ROW_W;
  localparam logic [63:0] ROW_DEF64  = span_mask(ROW_LO, ROW_W);
  localparam logic [63:0] BANK_DEF64 = span_mask(BANK_LO, BANK_W);
  localparam logic [ADDR_W-1:0] ROW_DEF  = ROW_DEF64[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] BANK_DEF = BANK_DEF64[ADDR_W-1:0];

  always_comb begin
    row_mask  = mask_ovr ? row_mask_in  : ROW_DEF;
    bank_mask = mask_ovr ? bank_mask_in : BANK_DEF;
  end
endmodule

// File: rtl/rbc_field_split.sv
module rbc_field_split #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 2,
  parameter int COL_W  = 9,
  parameter int ROW_W  = 13,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [ADDR_W-1:0] cmd_addr,
  output logic [COL_W-1:0]  col_field,
  output logic [ROW_W-1:0]  row_field,
  output logic [BANK_W-1:0] bank_field
);
  localparam int ROW_LO  = OFF_W + COL_W;
  localparam int BANK_LO = ROW_LO + ROW_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      col_field  <= '0;
      row_field  <= '0;
      bank_field <= '0;
    end else if (cmd_valid) begin
      col_field  <= cmd_addr[OFF_W +: COL_W];
      row_field  <= cmd_addr[ROW_LO +: ROW_W];
      bank_field <= cmd_addr[BANK_LO +: BANK_W];
    end
  end

  // R12: fields hold when no command is accepted
  a_r12_fields_hold: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |=> $stable(col_field) && $stable(row_field) && $stable(bank_field));
endmodule

// File: rtl/rbc_compare.sv
module rbc_compare #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [ADDR_W-1:0] row_mask,
  input  logic [ADDR_W-1:0] bank_mask,
  output logic              row_conflict,
  output logic              bank_conflict
);
  logic [ADDR_W-1:0] prev_q;
  logic              have_prev_q;
  logic [ADDR_W-1:0] diff;
  logic              row_hit, bank_hit;

  always_comb begin
    diff     = cmd_addr ^ prev_q;
    row_hit  = !have_prev_q || (|(diff & row_mask));
    bank_hit = !have_prev_q || (|(diff & bank_mask));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q        <= '0;
      have_prev_q   <= 1'b0;
      row_conflict  <= 1'b0;
      bank_conflict <= 1'b0;
    end else if (cmd_valid) begin
      prev_q        <= cmd_addr;
      have_prev_q   <= 1'b1;
      row_conflict  <= row_hit;
      bank_conflict <= bank_hit;
    end
  end

  a_r6_first_opens: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && !have_prev_q |=> row_conflict && bank_conflict);
  a_r9_prev_hold: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |=> $stable(prev_q) && $stable(have_prev_q));
  a_r12_flags_hold: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |=> $stable(row_conflict) && $stable(bank_conflict));
endmodule

// File: rtl/rowbank_conflict_detect.sv
module rowbank_conflict_detect #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int COL_W  = 9,
  parameter int ROW_W  = 13,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              mask_ovr,
  input  logic [ADDR_W-1:0] row_mask_in,
  input  logic [ADDR_W-1:0] bank_mask_in,
  output logic              out_valid,
  output logic              row_conflict,
  output logic              bank_conflict,
  output logic [COL_W-1:0]  col_field,
  output logic [ROW_W-1:0]  row_field,
  output logic [BANK_W-1:0] bank_field
);
  localparam int OFF_W = $clog2(DATA_W / 8);

  logic [ADDR_W-1:0] row_mask, bank_mask;

  rbc_mask_gen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .COL_W(COL_W),
                 .ROW_W(ROW_W), .BANK_W(BANK_W)) u_mask (
    .mask_ovr(mask_ovr), .row_mask_in(row_mask_in), .bank_mask_in(bank_mask_in),
    .row_mask(row_mask), .bank_mask(bank_mask));

  rbc_compare #(.ADDR_W(ADDR_W)) u_cmp (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_addr(cmd_addr),
    .row_mask(row_mask), .bank_mask(bank_mask),
    .row_conflict(row_conflict), .bank_conflict(bank_conflict));

  rbc_field_split #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .COL_W(COL_W),
                    .ROW_W(ROW_W), .BANK_W(BANK_W)) u_split (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_addr(cmd_addr),
    .col_field(col_field), .row_field(row_field), .bank_field(bank_field));

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= cmd_valid;
  end

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> out_valid);
  a_r2_valid_idle: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |=> !out_valid);
  a_r3_col_decode: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> col_field == $past(cmd_addr[OFF_W +: COL_W]));
endmodule

// File: tb/rowbank_conflict_detect_test.sv
module rowbank_conflict_detect_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32, DW = 32, CW = 9, RW = 13, BW = 2;
  localparam int OFF = 2;
  localparam int ROW_LO = OFF + CW, BANK_LO = ROW_LO + RW;

  logic clk = 1'b0, rst = 1'b1, cmd_valid = 1'b0, mask_ovr = 1'b0;
  logic [AW-1:0] cmd_addr = '0, row_mask_in = '0, bank_mask_in = '0;
  logic out_valid, row_conflict, bank_conflict;
  logic [CW-1:0] col_field;
  logic [RW-1:0] row_field;
  logic [BW-1:0] bank_field;

  int checks = 0, errors = 0;

  // reference model state
  logic [AW-1:0] m_prev = '0;
  bit            m_have = 0;
  logic          e_valid = 0, e_row = 0, e_bank = 0;
  logic [CW-1:0] e_col = '0;
  logic [RW-1:0] e_rowf = '0;
  logic [BW-1:0] e_bankf = '0;
  string         e_tag = "R1";
  logic [AW-1:0] def_row_m, def_bank_m;

  always #(CLK_PERIOD/2) clk = ~clk;

  rowbank_conflict_detect #(.ADDR_W(AW), .DATA_W(DW), .COL_W(CW), .ROW_W(RW), .BANK_W(BW)) uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .mask_ovr(mask_ovr),
    .row_mask_in(row_mask_in), .bank_mask_in(bank_mask_in), .out_valid(out_valid),
    .row_conflict(row_conflict), .bank_conflict(bank_conflict),
    .col_field(col_field), .row_field(row_field), .bank_field(bank_field));

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [AW-1:0] mk(input int bank, input int row, input int col,
                                        input int off, input int upper);
    logic [AW-1:0] a;
    a = AW'(off % (1 << OFF));
    a = a | (AW'(col % (1 << CW)) << OFF);
    a = a | (AW'(row % (1 << RW)) << ROW_LO);
    a = a | (AW'(bank % (1 << BW)) << BANK_LO);
    a = a | (AW'(upper) << (BANK_LO + BW));
    return a;
  endfunction

  task automatic compare_outputs();
    string ft;
    chk("R2 out_valid", out_valid, e_valid);
    ft = e_valid ? e_tag : "R12";
    chk({ft, " row_conflict"}, row_conflict, e_row);
    chk({ft, " bank_conflict"}, bank_conflict, e_bank);
    chk(e_valid ? "R3 col_field" : "R12 col_field", col_field, e_col);
    chk(e_valid ? "R4 row_field" : "R12 row_field", row_field, e_rowf);
    chk(e_valid ? "R5 bank_field" : "R12 bank_field", bank_field, e_bankf);
  endtask

  task automatic step(input bit v, input logic [AW-1:0] a, input bit ovr,
                      input logic [AW-1:0] rm, input logic [AW-1:0] bm, input string tag);
    logic [AW-1:0] erm, ebm;
    @(negedge clk);
    compare_outputs();
    cmd_valid = v; cmd_addr = a; mask_ovr = ovr; row_mask_in = rm; bank_mask_in = bm;
    erm = ovr ? rm : def_row_m;
    ebm = ovr ? bm : def_bank_m;
    e_valid = v;
    if (v) begin
      e_tag   = m_have ? tag : "R6";
      e_row   = !m_have || (((a ^ m_prev) & erm) != 0);
      e_bank  = !m_have || (((a ^ m_prev) & ebm) != 0);
      e_col   = CW'((a >> OFF) & ((1 << CW) - 1));
      e_rowf  = RW'((a >> ROW_LO) & ((1 << RW) - 1));
      e_bankf = BW'((a >> BANK_LO) & ((1 << BW) - 1));
      m_prev  = a;
      m_have  = 1;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [AW-1:0] a, keep;
    def_row_m = '0; def_bank_m = '0;
    for (int i = 0; i < AW; i++) begin
      if (i >= ROW_LO && i < ROW_LO + RW) def_row_m[i] = 1'b1;
      if (i >= BANK_LO && i < BANK_LO + BW) def_bank_m[i] = 1'b1;
    end
    repeat (3) @(negedge clk);
    // R1: reset state while rst is high
    chk("R1 out_valid", out_valid, 0);
    chk("R1 row_conflict", row_conflict, 0);
    chk("R1 bank_conflict", bank_conflict, 0);
    chk("R1 col_field", col_field, 0);
    rst = 1'b0;
    // R6: first command after reset
    step(1, mk(1, 100, 5, 1, 0), 0, '0, '0, "R6");
    // R3 field positions: big-endian col 21-29 = port [10:2]
    step(1, 32'h0000_07FC, 0, '0, '0, "R8");
    // R10: only column/offset/upper bits change
    for (int i = 0; i < 6; i++) step(1, mk(0, 0, i * 37, i, i * 9), 0, '0, '0, "R10");
    // R7: row change, same bank
    step(1, mk(0, 7, 3, 0, 0), 0, '0, '0, "R7");
    // R8: bank change, same row
    step(1, mk(2, 7, 3, 0, 0), 0, '0, '0, "R8");
    step(1, mk(3, 8, 4, 0, 0), 0, '0, '0, "R8");
    // R9: idle cycles with foreign addresses
    keep = mk(3, 8, 4, 0, 0);
    for (int i = 0; i < 3; i++) step(0, mk(i, 500 + i, 1, 1, 63), 0, '0, '0, "R9");
    step(1, mk(3, 8, 99, 2, 0), 0, '0, '0, "R9");
    step(1, keep ^ 32'h0000_0800, 0, '0, '0, "R9");
    // R11: supplied masks
    step(1, 32'h8000_0000, 1, 32'h8000_0000, 32'h0000_0001, "R11");
    step(1, 32'h0000_0001, 1, 32'h8000_0000, 32'h0000_0001, "R11");
    step(1, 32'h0000_0001, 1, 32'h0000_0000, 32'hFFFF_FFFF, "R11");
    // random mix
    for (int i = 0; i < 300; i++) begin
      a = $urandom;
      if (i % 3 == 0) a = (a & ~(def_row_m | def_bank_m)) | (m_prev & (def_row_m | def_bank_m));
      step(($urandom % 4) != 0, a, (i % 7) == 0, $urandom, $urandom, "R7");
    end
    step(0, '0, 0, '0, '0, "R12");
    step(0, '0, 0, '0, '0, "R12");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule